// File: doc/BRIEF.md
# Serial Word-Time Window Generator

This block frames one serial transfer between two shift registers. A one-cycle `start` request opens a control window. The window stays high for exactly one word time, which is a fixed number of clock ticks set by the parameter `WORD_TICKS`. While the window is high, `bit_idx` reports which bit of the word is being moved. `done` marks the final tick.

The window comes from a set/reset storage bit. That bit enables a modulo-`WORD_TICKS` up-counter. A terminal-count decode ends the window. The decode samples only those counter bits that are 1 in the value `WORD_TICKS-1`. The surrounding control logic gates its shift enables with `window`, and uses `done` to move on to its next step. The default word is 8 ticks. Other lengths, such as 5 or 13 ticks, are obtained by changing the parameter alone.

Top module: `wordtime_gen`

## Requirements
- R1: When `start` is high at a clock edge while `window` is low, `window` is high in the next cycle and `bit_idx` is 0 in that cycle.
- R2: Once opened, `window` stays high for exactly `WORD_TICKS` consecutive cycles and is then low (default 8).
- R3: While `window` is high, `bit_idx` takes the values 0, 1, ..., `WORD_TICKS-1` in successive cycles. While `window` is low, `bit_idx` is 0.
- R4: `done` is high in exactly one cycle per window: the cycle in which `window` is high and `bit_idx` equals `WORD_TICKS-1`. It is low in all other cycles.
- R5: A `start` seen while `window` is high, including on the final tick, is ignored. The running window keeps its length and its index sequence, and no extra window follows it.
- R6: A `start` seen in the first low cycle after a window closes opens a new window in the next cycle. Holding `start` high therefore gives windows of `WORD_TICKS` cycles separated by one low cycle.
- R7: The synchronous reset `rst` (active high) forces `window` low and `bit_idx` to 0 after the clock edge at which it is sampled, even in the middle of a window.
- R8: `bit_idx` is ceil(log2(`WORD_TICKS`)) bits wide. The end of the window follows the modulus: `WORD_TICKS`=5 gives a 3-bit index and 5-cycle windows, and `WORD_TICKS`=13 gives a 4-bit index and 13-cycle windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to open a window |
| window | output | 1 | High for one word time |
| bit_idx | output | IDX_W | Index of the current bit in the word |
| done | output | 1 | High on the last tick of the window |

## Verification
The assertions take `rst` to be a clean level that is sampled at clock edges. They take `start` to be a plain level that can arrive in any cycle, so they make no assumption about how long it is held or how close together the pulses are. The stimulus changes `start` and `rst` only just after the falling edge. It covers single pulses, pulses inside a running window, a pulse on the final tick, a `start` held for several words, and a reset in the middle of a word. One `start` line drives instances with 8, 5 and 13 ticks at the same time.

// File: rtl/wordtime_gen.sv
module wordtime_gen #(
  parameter int unsigned WORD_TICKS = 8,
  localparam int unsigned IDX_W = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             window,
  output logic [IDX_W-1:0] bit_idx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_TICKS - 1);

  logic             open_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] tap;
  logic             stop;

  for (genvar b = 0; b < IDX_W; b++) begin : g_tap
    if (LAST[b]) begin : g_use
      assign tap[b] = cnt_q[b];
    end else begin : g_skip
      assign tap[b] = 1'b1;
    end
  end

  assign stop = open_q & (&tap);

  always_ff @(posedge clk) begin
    if (rst)       open_q <= 1'b0;
    else if (stop) open_q <= 1'b0;
    else if (start) open_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !open_q || stop) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign window  = open_q;
  assign bit_idx = cnt_q;
  assign done    = stop;

endmodule

// File: rtl/wordtime_gen_chk.sv
module wordtime_gen_chk #(
  parameter int unsigned WORD_TICKS = 8,
  localparam int unsigned IDX_W = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             window,
  input logic [IDX_W-1:0] bit_idx,
  input logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_TICKS - 1);

  a_r1_open: assert property (@(posedge clk) disable iff (rst)
    (!window && start) |=> (window && bit_idx == '0));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !window |-> (bit_idx == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (window && !done) |=> (window && bit_idx == IDX_W'($past(bit_idx) + 1'b1)));

  a_r4_done_at_last: assert property (@(posedge clk) disable iff (rst)
    done |-> (window && bit_idx == LAST));

  a_r4_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_close: assert property (@(posedge clk) disable iff (rst)
    done |=> (!window && bit_idx == '0));

  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    window |-> (bit_idx <= LAST));

  a_r7_reset: assert property (@(posedge clk)
    rst |=> (!window && bit_idx == '0 && !done));

endmodule

bind wordtime_gen wordtime_gen_chk #(.WORD_TICKS(WORD_TICKS)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .window(window), .bit_idx(bit_idx), .done(done)
);

// File: tb/tb_wordtime_gen.sv
module tb_wordtime_gen;

  localparam int unsigned N  = 8;
  localparam int unsigned IW = $clog2(N);

  typedef struct packed {
    logic          win;
    logic [IW-1:0] idx;
    logic          dn;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;

  logic          win8, dn8;
  logic [IW-1:0] idx8;
  logic          win5, dn5;
  logic [2:0]    idx5;
  logic          win13, dn13;
  logic [3:0]    idx13;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  bit last_exp_win = 1'b0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  wordtime_gen #(.WORD_TICKS(N)) dut (
    .clk(clk), .rst(rst), .start(start), .window(win8), .bit_idx(idx8), .done(dn8));
  wordtime_gen #(.WORD_TICKS(5)) dut5 (
    .clk(clk), .rst(rst), .start(start), .window(win5), .bit_idx(idx5), .done(dn5));
  wordtime_gen #(.WORD_TICKS(13)) dut13 (
    .clk(clk), .rst(rst), .start(start), .window(win13), .bit_idx(idx13), .done(dn13));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, pushes expectations for accepted starts (R1, R5, R6)
  task automatic drive(input bit s);
    @(negedge clk);
    #1;
    start = s;
    if (s && q.size() == 0 && !last_exp_win && !rst) begin
      for (int i = 0; i < int'(N); i++) begin
        exp_t e;
        e.win = 1'b1;
        e.idx = IW'(i);
        e.dn  = (i == int'(N) - 1);
        q.push_back(e);
      end
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    #1;
    rst = 1'b1;
    start = 1'b0;
    q.delete();
    @(negedge clk);
    #1;
    rst = 1'b0;
  endtask

  // monitor / scoreboard for the default instance
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else e = '0;
      last_exp_win = e.win;
      chk(win8 === e.win, e.win ? "R2 window" : "R5 window idle", int'(win8), int'(e.win));
      chk(idx8 === e.idx, "R3 bit_idx", int'(idx8), int'(e.idx));
      chk(dn8 === e.dn, "R4 done", int'(dn8), int'(e.dn));
    end
  end

  // length monitors for the 5- and 13-tick instances (R8)
  int run5 = 0, run13 = 0;
  bit prev5 = 1'b0, prev13 = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (win5) run5++;
      if (prev5 && !win5) begin
        if (!rst) chk(run5 == 5, "R8 len5", run5, 5);
        run5 = 0;
      end
      if (dn5) chk(idx5 == 3'd4, "R8 last5", int'(idx5), 4);
      prev5 = win5;
      if (win13) run13++;
      if (prev13 && !win13) begin
        if (!rst) chk(run13 == 13, "R8 len13", run13, 13);
        run13 = 0;
      end
      if (dn13) chk(idx13 == 4'd12, "R8 last13", int'(idx13), 12);
      prev13 = win13;
    end
  end

  initial begin
    fork
      begin
        @(posedge clk);
        @(negedge clk);
        chk(win8 === 1'b0 && idx8 === '0 && dn8 === 1'b0, "R7 reset state", int'(win8), 0);
        mon_on = 1'b1;
        #1 rst = 1'b0;
        // single pulse, full word (R1 R2 R3 R4)
        drive(1'b1);
        drive(1'b0);
        repeat (16) drive(1'b0);
        // starts inside a running window (R5)
        drive(1'b1);
        drive(1'b0);
        drive(1'b0);
        drive(1'b1);
        drive(1'b0);
        drive(1'b1);
        repeat (14) drive(1'b0);
        // start exactly on the final tick is ignored, next cycle accepted (R5 R6)
        drive(1'b1);
        repeat (N - 1) drive(1'b0);
        drive(1'b1);
        drive(1'b1);
        drive(1'b0);
        repeat (16) drive(1'b0);
        // start held high over several words (R6)
        repeat (40) drive(1'b1);
        drive(1'b0);
        repeat (16) drive(1'b0);
        // reset mid-window (R7)
        drive(1'b1);
        drive(1'b0);
        repeat (3) drive(1'b0);
        pulse_reset();
        repeat (4) drive(1'b0);
        drive(1'b1);
        repeat (20) drive(1'b0);
        @(negedge clk);
        chk(q.size() == 0, "R2 queue drained", q.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule